// File: doc/BRIEF.md
# Load/Store Multiple Word Sequencer

This block carries out a multi-register word transfer between memory and the register file. A request gives a byte address, a starting register and a base register. On a load, the block fills every register from the starting one up to the last register with consecutive words from memory. On a store, it writes those registers out to consecutive words. The pipeline hands over a request through a valid/ready handshake. The sequencer then works through the registers one word at a time over a simple request/acknowledge memory port. It reads store data from, and writes load data to, a register file port.

The address must be word aligned. A misaligned address is rejected before any memory access or register write. The base register needs no special treatment when it falls inside the loaded range: it is written from its own word slot like any other register, and no error is raised. A one-cycle pulse ends every sequence. The pulse is a done pulse after the final word, or an alignment-error pulse for a rejected request.

Top module: `lsm_seq`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `mem_req_o`, `rf_we_o`, `done_o` and `align_err_o` are all 0.
- R2: If either of bits [1:0] of `req_ea_i` is 1 when a request is accepted, `align_err_o` is high for exactly the following cycle. No memory request and no register write take place for that request, and `done_o` stays low.
- R3: On a load (`req_store_i`=0) starting at register F with address A, register F+k receives the word read from address A+4k, for k = 0 up to 31−F. The accesses go in ascending order, and registers below F are left unchanged.
- R4: On a load whose base register B satisfies F ≤ B ≤ 31, register B receives the word at A+4(B−F), and the sequence finishes with `done_o` and without an error.
- R5: On a store (`req_store_i`=1), the word at address A+4k receives the contents of register F+k for k = 0 up to 31−F, and all other memory words are left unchanged.
- R6: Only one memory access is in flight at a time. While `mem_req_o` is high and `mem_ack_i` is low, `mem_req_o`, `mem_addr_o` and `mem_we_o` hold their values. An access completes in the cycle in which `mem_req_o` and `mem_ack_i` are both high.
- R7: `done_o` is high for exactly one cycle, the cycle after the last access completes. A sequence makes exactly 32−F accesses.
- R8: `req_ready_o` is low from the cycle after acceptance until the end pulse has been given. Requests presented during that time are ignored, and `req_ready_o` returns to 1 in the cycle after the pulse.
- R9: With F = 31, exactly one access is made, to address A, and `done_o` follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_store_i | input | 1 | 1 = store sequence, 0 = load sequence |
| req_ea_i | input | ADDR_W | Byte address of the first word |
| req_first_i | input | REG_W | First register of the range |
| req_base_i | input | REG_W | Base address register number |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | ADDR_W | Word byte address |
| mem_wdata_o | output | DATA_W | Store data |
| mem_ack_i | input | 1 | Access completes this cycle |
| mem_rdata_i | input | DATA_W | Load data, valid with ack |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | REG_W | Register file write index |
| rf_wdata_o | output | DATA_W | Register file write data |
| rf_raddr_o | output | REG_W | Register file read index |
| rf_rdata_i | input | DATA_W | Register file read data, combinational |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| align_err_o | output | 1 | One-cycle misaligned-request pulse |

## Verification
The register index and the word address advance together. If either one drifts, a load puts a word into the wrong register, or a store writes the wrong slot, and the bench sees this at the first access after the fault. A stuck state machine shows up in two ways: the end pulse is missing or lasts more than one cycle, or ready stays low, which the bench sees within one cycle of the expected end. If a busy sequencer takes a new request, it changes the number of accesses or the final register and memory contents, and the bench compares both after every sequence.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } lsm_state_e;
endpackage

// File: rtl/lsm_align_chk.sv
module lsm_align_chk #(
  parameter int ALIGN_BITS = 2
) (
  input  logic [ALIGN_BITS-1:0] ea_lo_i,
  output logic                  misaligned_o
);
  assign misaligned_o = |ea_lo_i;
endmodule

// File: rtl/lsm_walker.sv
module lsm_walker #(
  parameter int ADDR_W     = 32,
  parameter int REG_W      = 5,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic [REG_W-1:0]  first_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [REG_W-1:0]  idx_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_BITS;

  logic [ADDR_W-1:0] addr_q;
  logic [REG_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      addr_q <= ea_i;
      idx_q  <= first_i;
    end else if (step_i && !last_o) begin
      addr_q <= addr_q + STEP;
      idx_q  <= idx_q + REG_W'(1);
    end
  end

  assign addr_o = addr_q;
  assign idx_o  = idx_q;
  assign last_o = &idx_q;

  assert_walk_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !last_o && !start_i) |=>
      (addr_o == $past(addr_o) + STEP) && (idx_o == $past(idx_o) + REG_W'(1)));
endmodule

// File: rtl/lsm_ctrl.sv
module lsm_ctrl
  import lsm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic misaligned_i,
  input  logic last_i,
  input  logic ack_i,
  output logic ready_o,
  output logic start_o,
  output logic xfer_o,
  output logic step_o,
  output logic done_o,
  output logic err_o
);
  lsm_state_e state_q, state_d;
  logic       err_q, err_d;

  assign ready_o = (state_q == ST_IDLE);
  assign start_o = ready_o && req_valid_i;
  assign xfer_o  = (state_q == ST_XFER);
  assign step_o  = xfer_o && ack_i;

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: if (start_o) begin
        state_d = misaligned_i ? ST_FIN : ST_XFER;
        err_d   = misaligned_i;
      end
      ST_XFER: if (step_o && last_i) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  assign done_o = (state_q == ST_FIN) && !err_q;
  assign err_o  = (state_q == ST_FIN) && err_q;

  assert_err_path_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && misaligned_i) |=> (err_o && !xfer_o));
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_end_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o}));
  assert_busy_after_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !ready_o);
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_store_i,
  input  logic [ADDR_W-1:0] req_ea_i,
  input  logic [REG_W-1:0]  req_first_i,
  input  logic [REG_W-1:0]  req_base_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rf_we_o,
  output logic [REG_W-1:0]  rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic [REG_W-1:0]  rf_raddr_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic              done_o,
  output logic              align_err_o
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int ALIGN_BITS = $clog2(WORD_BYTES);

  logic              misaligned, start, xfer, step, last;
  logic [REG_W-1:0]  idx;
  logic              store_q;
  logic [ADDR_W-1:0] ea_q;
  logic [REG_W-1:0]  first_q, base_q;

  lsm_align_chk #(.ALIGN_BITS(ALIGN_BITS)) u_align (
    .ea_lo_i      (req_ea_i[ALIGN_BITS-1:0]),
    .misaligned_o (misaligned)
  );

  lsm_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .misaligned_i (misaligned),
    .last_i       (last),
    .ack_i        (mem_ack_i),
    .ready_o      (req_ready_o),
    .start_o      (start),
    .xfer_o       (xfer),
    .step_o       (step),
    .done_o       (done_o),
    .err_o        (align_err_o)
  );

  lsm_walker #(.ADDR_W(ADDR_W), .REG_W(REG_W), .ALIGN_BITS(ALIGN_BITS)) u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .ea_i    (req_ea_i),
    .first_i (req_first_i),
    .step_i  (step),
    .addr_o  (mem_addr_o),
    .idx_o   (idx),
    .last_o  (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q <= 1'b0;
      ea_q    <= '0;
      first_q <= '0;
      base_q  <= '0;
    end else if (start) begin
      store_q <= req_store_i;
      ea_q    <= req_ea_i;
      first_q <= req_first_i;
      base_q  <= req_base_i;
    end
  end

  assign mem_req_o   = xfer;
  assign mem_we_o    = xfer && store_q;
  assign mem_wdata_o = rf_rdata_i;
  assign rf_raddr_o  = idx;
  assign rf_waddr_o  = idx;
  assign rf_wdata_o  = mem_rdata_i;
  assign rf_we_o     = xfer && !store_q && mem_ack_i;

  assert_req_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  // base register inside the range reads its own slot
  assert_base_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && (rf_waddr_o == base_q)) |->
      (mem_addr_o == ea_q + (ADDR_W'(base_q - first_q) << ALIGN_BITS)));
  assert_busy_no_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
endmodule

// File: tb/lsm_seq_tb_top.sv
`timescale 1ns/1ps
module lsm_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0;
  logic [31:0] req_ea = '0;
  logic [4:0]  req_first = '0, req_base = '0;
  logic        req_ready, mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        rf_we, done, align_err;
  logic [4:0]  rf_waddr, rf_raddr;
  logic [31:0] rf_wdata, rf_rdata;

  logic [31:0] mem  [128];
  logic [31:0] regs [32];
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  assign rf_rdata = regs[rf_raddr];

  lsm_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_store_i(req_store),
    .req_ea_i(req_ea), .req_first_i(req_first), .req_base_i(req_base),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata),
    .done_o(done), .align_err_o(align_err)
  );

  // {store, ea[7:0], first, base, latency}
  localparam logic [20:0] VEC [6] = '{
    {1'b0, 8'h00, 5'd20, 5'd3,  2'd0},
    {1'b0, 8'h10, 5'd24, 5'd27, 2'd1},
    {1'b1, 8'h20, 5'd16, 5'd0,  2'd2},
    {1'b0, 8'h04, 5'd0,  5'd0,  2'd0},
    {1'b1, 8'h08, 5'd28, 5'd30, 2'd3},
    {1'b0, 8'h3C, 5'd31, 5'd31, 2'd1}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic run_op(input logic st, input logic [31:0] ea, input logic [4:0] first,
                        input logic [4:0] base, input int lat);
    logic [31:0] mem_s [128];
    logic [31:0] reg_s [32];
    bit   bad_ea, end_seen, waiting, order_ok, hold_ok, busy_ok;
    int   n_acc, wait_cnt, n_done, n_err, n_cyc, wb, n_exp;
    logic [31:0] prev_addr;
    for (int i = 0; i < 128; i++) mem_s[i] = mem[i];
    for (int i = 0; i < 32; i++) reg_s[i] = regs[i];
    bad_ea = |ea[1:0];
    n_exp = 32 - int'(first);
    wb = int'(ea[8:2]);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_ea = ea; req_first = first; req_base = base;
    @(negedge clk);
    // junk request held while busy: must be ignored (R8)
    req_store = ~st; req_ea = 32'h81; req_first = 5'd1; req_base = 5'd2;
    n_acc = 0; wait_cnt = 0; n_done = 0; n_err = 0; n_cyc = 0;
    end_seen = 0; waiting = 0; order_ok = 1; hold_ok = 1; busy_ok = 1;
    prev_addr = '0;
    while (!end_seen && n_cyc < 400) begin
      if (mem_req && wait_cnt >= lat) begin
        mem_ack = 1'b1; mem_rdata = mem[mem_addr[8:2]];
      end else begin
        mem_ack = 1'b0;
        if (mem_req) wait_cnt++;
      end
      #1;
      if (req_ready) busy_ok = 0;
      if (mem_req) begin
        if (waiting && mem_addr != prev_addr) hold_ok = 0;
        prev_addr = mem_addr;
        waiting = !mem_ack;
      end
      if (mem_req && mem_ack) begin
        if (mem_addr != ea + 32'(4 * n_acc) || mem_we != st) order_ok = 0;
        if (st) begin
          if (rf_raddr != 5'(int'(first) + n_acc)) order_ok = 0;
          mem[mem_addr[8:2]] = mem_wdata;
        end else begin
          if (!rf_we || rf_waddr != 5'(int'(first) + n_acc)) order_ok = 0;
          regs[rf_waddr] = rf_wdata;
        end
        n_acc++; wait_cnt = 0;
      end else if (rf_we) order_ok = 0;
      if (done) n_done++;
      if (align_err) n_err++;
      end_seen = done || align_err;
      n_cyc++;
      @(negedge clk);
    end
    req_valid = 1'b0; mem_ack = 1'b0;
    #1;
    check(!done && !align_err, "R7 end pulse one cycle", {30'd0, done, align_err}, 32'd0);
    check(req_ready == 1'b1, "R8 ready after end", {31'd0, req_ready}, 32'd1);
    check(busy_ok, "R8 ready low while busy", {31'd0, busy_ok}, 32'd1);
    if (bad_ea) begin
      check(n_err == 1 && n_done == 0, "R2 align error pulse", 32'(n_err), 32'd1);
      check(n_acc == 0, "R2 no access on misalign", 32'(n_acc), 32'd0);
      for (int i = 0; i < 32; i++)
        check(regs[i] == reg_s[i], "R2 registers untouched", regs[i], reg_s[i]);
    end else begin
      check(n_done == 1 && n_err == 0, "R7 done once", 32'(n_done), 32'd1);
      check(n_acc == n_exp, "R7 access count", 32'(n_acc), 32'(n_exp));
      check(order_ok, st ? "R5 store order" : "R3 load order", {31'd0, order_ok}, 32'd1);
      check(hold_ok, "R6 request held until ack", {31'd0, hold_ok}, 32'd1);
      if (first == 5'd31)
        check(n_acc == 1, "R9 single word", 32'(n_acc), 32'd1);
      if (st) begin
        for (int k = 0; k < n_exp; k++)
          check(mem[wb + k] == reg_s[int'(first) + k], "R5 stored word", mem[wb + k], reg_s[int'(first) + k]);
        for (int i = 0; i < 128; i++)
          if (i < wb || i >= wb + n_exp)
            check(mem[i] == mem_s[i], "R5 other memory untouched", mem[i], mem_s[i]);
      end else begin
        for (int k = int'(first); k < 32; k++)
          check(regs[k] == mem_s[wb + k - int'(first)], "R3 loaded register", regs[k], mem_s[wb + k - int'(first)]);
        for (int k = 0; k < int'(first); k++)
          check(regs[k] == reg_s[k], "R3 lower register untouched", regs[k], reg_s[k]);
        if (base >= first)
          check(regs[base] == mem_s[wb + int'(base) - int'(first)], "R4 base from own slot",
                regs[base], mem_s[wb + int'(base) - int'(first)]);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'h5A00_0000 + 32'(i * 32'h0101);
    for (int i = 0; i < 32; i++) regs[i] = 32'hA000_0000 + 32'(i);
    repeat (3) @(negedge clk);
    #1;
    check(req_ready && !mem_req && !rf_we && !done && !align_err, "R1 reset outputs",
          {27'd0, req_ready, mem_req, rf_we, done, align_err}, 32'h10);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++)
      run_op(VEC[i][20], {24'h0, VEC[i][19:12]}, VEC[i][11:7], VEC[i][6:2], int'(VEC[i][1:0]));
    // misaligned addresses, both directions (R2)
    run_op(1'b0, 32'h01, 5'd10, 5'd12, 0);
    run_op(1'b1, 32'h02, 5'd4, 5'd4, 1);
    run_op(1'b0, 32'h13, 5'd31, 5'd0, 0);
    // base equals first register, slow memory (R4)
    run_op(1'b0, 32'h40, 5'd8, 5'd8, 2);
    report();
  end
endmodule